// File: doc/BRIEF.md
# Serial Flash Page-Program Command Interpreter

This block sits behind a clocked synchronous serial receiver and turns the incoming byte stream into operations on a flash array. Each byte arrives with a one-cycle valid strobe. The position of a byte in a transfer decides what it means. The first byte is an opcode, and the bytes after it are either operands or page data, depending on that opcode.

Two opcodes are understood. The first clears the sticky error flags in the status register. The second collects a page number and then 256 data bytes into an internal page buffer. After that it checks whether the target page may be written. If it may, the buffer goes out on a byte-wide write port to the flash array, one byte per cycle. A page cannot be written if it lies in a locked block, lies beyond the end of the array, or has already been programmed since reset. Any of these raises an error flag and nothing is written.

The block drives a BUSY output while it carries out an operation. Bytes that arrive while BUSY is high are dropped. Lock bits for each block are loaded from a parameter at reset.

Top module: `flash_cmd_interp`

## Requirements
- R1: After reset, `busy` is 0 and `statusOut` reads 0x80. Bit 7 is the ready flag, bit 4 is the program error, and bit 3 is the lock/range error. Bits 6, 2, 1 and 0 always read 0.
- R2: A first byte of 0x50 raises `busy` in the cycle after its strobe, for exactly one cycle. When `busy` falls, status bits 5, 4 and 3 read 0 and bit 7 reads 1.
- R3: A first byte of 0x41 starts a page program. The 2nd byte is address bits 15:8 and the 3rd byte is address bits 23:16. The next 256 bytes are page data. On success, 256 writes follow on consecutive cycles. Their addresses are {bits 23:8, 8'h00} up to {bits 23:8, 8'hFF}, and the data appear in the order the bytes arrived.
- R4: `busy` goes high in the cycle after the 256th data byte. On success it stays high through the last write, for 257 cycles in all. Status bit 7 always equals the inverse of `busy`.
- R5: A byte strobed while `busy` is high has no effect on status, framing or writes, even when it is 0x50 or 0x41.
- R6: A first byte that is neither 0x50 nor 0x41 is discarded. `busy` stays low, and the next byte is again taken as an opcode.
- R7: A page whose block is locked produces no write and sets status bit 3, with `busy` high for one cycle. Block = page number / PAGES_PER_BLOCK, and bit n of LOCK_INIT locks block n (default: block 2, pages 32–47).
- R8: A page that was already programmed since reset produces no write and sets status bit 4, with `busy` high for one cycle.
- R9: A page number of PAGE_CNT (default 64) or above produces no write and sets status bit 3.
- R10: Status bits 3 and 4 stay set until a 0x50 clear. A clear does not reset the record of programmed pages, so a page cannot be rewritten after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | One-cycle strobe marking a received byte |
| rxByte | input | 8 | Received byte |
| busy | output | 1 | High while an operation executes |
| statusOut | output | 8 | Status register |
| flashWrEn | output | 1 | Write strobe to the flash array |
| flashWrAddr | output | ADDR_W | Byte address of the write |
| flashWrData | output | 8 | Byte to write |

## Verification
The hardest situation to reach is a stream of bytes arriving while the block is busy, because those bytes must leave no trace. The stimulus starts a valid page write and, during its 257 busy cycles, sends a clear opcode and a program opcode. It first sets a program error, so a clear that slipped through would show in the status afterwards. The next transfer then begins with a clear opcode, which confirms that framing is still at the first byte. The same data pattern covers every byte value, so data bytes equal to opcodes are also exercised.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] OP_CLEAR_STATUS = 8'h50;
  localparam logic [7:0] OP_PAGE_PROGRAM = 8'h41;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_ADDR_MID,
    ST_ADDR_HIGH,
    ST_DATA,
    ST_CHECK,
    ST_WRITE,
    ST_CLEAR
  } cmdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddrMid;
    logic loadAddrHigh;
    logic storeByte;
    logic clearErrors;
    logic setLockErr;
    logic setProgErr;
    logic markProgrammed;
  } ctrlStrobes_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  localparam int IDX_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [7:0]       rxByte,
  input  logic             pageBlocked,
  input  logic             pageDone,
  output ctrlStrobes_t     strobes,
  output logic [IDX_W-1:0] byteIdx,
  output logic             busy,
  output logic             wrEn
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

  cmdState_t state, stateNext;
  logic [IDX_W-1:0] idxNext;

  always_comb begin
    stateNext = state;
    idxNext   = byteIdx;
    strobes   = '0;
    unique case (state)
      ST_OPCODE: begin
        if (rxValid) begin
          if (rxByte == OP_CLEAR_STATUS)      stateNext = ST_CLEAR;
          else if (rxByte == OP_PAGE_PROGRAM) stateNext = ST_ADDR_MID;
        end
      end
      ST_ADDR_MID: begin
        if (rxValid) begin
          strobes.loadAddrMid = 1'b1;
          stateNext = ST_ADDR_HIGH;
        end
      end
      ST_ADDR_HIGH: begin
        if (rxValid) begin
          strobes.loadAddrHigh = 1'b1;
          idxNext   = '0;
          stateNext = ST_DATA;
        end
      end
      ST_DATA: begin
        if (rxValid) begin
          strobes.storeByte = 1'b1;
          if (byteIdx == LAST_IDX) stateNext = ST_CHECK;
          else                     idxNext = byteIdx + 1'b1;
        end
      end
      ST_CHECK: begin
        if (pageBlocked) begin
          strobes.setLockErr = 1'b1;
          stateNext = ST_OPCODE;
        end else if (pageDone) begin
          strobes.setProgErr = 1'b1;
          stateNext = ST_OPCODE;
        end else begin
          idxNext   = '0;
          stateNext = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (byteIdx == LAST_IDX) begin
          strobes.markProgrammed = 1'b1;
          stateNext = ST_OPCODE;
        end else begin
          idxNext = byteIdx + 1'b1;
        end
      end
      ST_CLEAR: begin
        strobes.clearErrors = 1'b1;
        stateNext = ST_OPCODE;
      end
      default: stateNext = ST_OPCODE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_OPCODE;
      byteIdx <= '0;
    end else begin
      state   <= stateNext;
      byteIdx <= idxNext;
    end
  end

  assign busy = (state == ST_CHECK) || (state == ST_WRITE) || (state == ST_CLEAR);
  assign wrEn = (state == ST_WRITE);

endmodule

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int PAGE_BYTES      = 256,
  parameter int PAGE_CNT        = 64,
  parameter int PAGES_PER_BLOCK = 16,
  parameter logic [PAGE_CNT/PAGES_PER_BLOCK-1:0] LOCK_INIT = '0,
  localparam int IDX_W      = $clog2(PAGE_BYTES),
  localparam int PAGE_W     = ADDR_W - IDX_W,
  localparam int SEL_W      = $clog2(PAGE_CNT),
  localparam int BLK_SHIFT  = $clog2(PAGES_PER_BLOCK),
  localparam int NUM_BLOCKS = PAGE_CNT / PAGES_PER_BLOCK
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic [7:0]        rxByte,
  input  logic              busy,
  output logic              pageBlocked,
  output logic              pageDone,
  output logic [7:0]        statusOut,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData
);

  localparam logic [PAGE_W-1:0] PAGE_LIMIT = PAGE_W'(PAGE_CNT);
  localparam int HALF_W = PAGE_W / 2;

  logic [7:0]          pageBuf [PAGE_BYTES];
  logic [PAGE_W-1:0]   pageNum;
  logic [PAGE_CNT-1:0] programmed;
  logic [NUM_BLOCKS-1:0] lockBits;
  logic                lockErr, progErr;

  logic [SEL_W-1:0]         pageSel;
  logic [SEL_W-BLK_SHIFT-1:0] blockSel;
  logic                     outOfRange;

  // page number register: two operand bytes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageNum <= '0;
    end else begin
      if (strobes.loadAddrMid)  pageNum[HALF_W-1:0]      <= rxByte[HALF_W-1:0];
      if (strobes.loadAddrHigh) pageNum[PAGE_W-1:HALF_W] <= rxByte[PAGE_W-HALF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.storeByte) pageBuf[byteIdx] <= rxByte;
  end

  assign pageSel    = pageNum[SEL_W-1:0];
  assign blockSel   = pageSel[SEL_W-1:BLK_SHIFT];
  assign outOfRange = (pageNum >= PAGE_LIMIT);
  assign pageBlocked = outOfRange || lockBits[blockSel];
  assign pageDone    = programmed[pageSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      programmed <= '0;
      lockBits   <= LOCK_INIT;
    end else if (strobes.markProgrammed) begin
      programmed[pageSel] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockErr <= 1'b0;
      progErr <= 1'b0;
    end else if (strobes.clearErrors) begin
      lockErr <= 1'b0;
      progErr <= 1'b0;
    end else begin
      if (strobes.setLockErr) lockErr <= 1'b1;
      if (strobes.setProgErr) progErr <= 1'b1;
    end
  end

  // bit 5 (erase error) has no source in this block and reads 0
  assign statusOut = {~busy, 1'b0, 1'b0, progErr, lockErr, 3'b000};
  assign wrAddr    = {pageNum, byteIdx};
  assign wrData    = pageBuf[byteIdx];

endmodule

// File: rtl/flash_cmd_interp.sv
module flash_cmd_interp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int PAGE_BYTES      = 256,
  parameter int PAGE_CNT        = 64,
  parameter int PAGES_PER_BLOCK = 16,
  parameter logic [PAGE_CNT/PAGES_PER_BLOCK-1:0] LOCK_INIT = 4'b0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              busy,
  output logic [7:0]        statusOut,
  output logic              flashWrEn,
  output logic [ADDR_W-1:0] flashWrAddr,
  output logic [7:0]        flashWrData
);

  localparam int IDX_W = $clog2(PAGE_BYTES);

  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] byteIdx;
  logic             pageBlocked, pageDone;

  flash_cmd_ctrl #(.PAGE_BYTES(PAGE_BYTES)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .rxValid     (rxValid),
    .rxByte      (rxByte),
    .pageBlocked (pageBlocked),
    .pageDone    (pageDone),
    .strobes     (strobes),
    .byteIdx     (byteIdx),
    .busy        (busy),
    .wrEn        (flashWrEn)
  );

  flash_cmd_datapath #(
    .ADDR_W          (ADDR_W),
    .PAGE_BYTES      (PAGE_BYTES),
    .PAGE_CNT        (PAGE_CNT),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .LOCK_INIT       (LOCK_INIT)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .byteIdx     (byteIdx),
    .rxByte      (rxByte),
    .busy        (busy),
    .pageBlocked (pageBlocked),
    .pageDone    (pageDone),
    .statusOut   (statusOut),
    .wrAddr      (flashWrAddr),
    .wrData      (flashWrData)
  );

endmodule

// File: rtl/flash_cmd_interp_chk.sv
module flash_cmd_interp_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic [7:0]        statusOut,
  input logic              flashWrEn,
  input logic [ADDR_W-1:0] flashWrAddr
);

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[6] == 1'b0) && (statusOut[2:0] == 3'b000));

  assert_write_while_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    flashWrEn |-> busy);

  assert_page_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWrEn) |-> (flashWrAddr[7:0] == 8'h00));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (flashWrEn && $past(flashWrEn)) |-> (flashWrAddr[7:0] == $past(flashWrAddr[7:0]) + 8'd1));

  assert_ready_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[7] == !busy);

  assert_prog_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusOut[4]) |-> $past(busy));

  assert_lock_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusOut[3]) |-> $past(busy));

endmodule

bind flash_cmd_interp flash_cmd_interp_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .statusOut   (statusOut),
  .flashWrEn   (flashWrEn),
  .flashWrAddr (flashWrAddr)
);

// File: tb/flash_cmd_interp_tb_top.sv
module flash_cmd_interp_tb_top;

  localparam int ADDR_W          = 24;
  localparam int PAGE_CNT        = 64;
  localparam int PAGES_PER_BLOCK = 16;
  localparam logic [3:0] LOCK_MODEL = 4'b0100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic busy;
  logic [7:0] statusOut;
  logic flashWrEn;
  logic [ADDR_W-1:0] flashWrAddr;
  logic [7:0] flashWrData;

  always #2.5 clk = ~clk;

  flash_cmd_interp dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .rxValid     (rxValid),
    .rxByte      (rxByte),
    .busy        (busy),
    .statusOut   (statusOut),
    .flashWrEn   (flashWrEn),
    .flashWrAddr (flashWrAddr),
    .flashWrData (flashWrData)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] expQ [$];
  logic [7:0]  flashMem [PAGE_CNT*256];
  bit          progModel [PAGE_CNT];
  bit          expLockErr = 0;
  bit          expProgErr = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int page, input int k);
    return 8'(k * 7 + page * 13 + 1);
  endfunction

  function automatic logic [7:0] expStatus();
    return {1'b1, 2'b00, expProgErr, expLockErr, 3'b000};
  endfunction

  // flash array model
  always @(posedge clk) begin
    if (flashWrEn && flashWrAddr < ADDR_W'(PAGE_CNT * 256))
      flashMem[flashWrAddr[13:0]] <= flashWrData;
  end

  // monitor: pop and compare every write
  always @(negedge clk) begin
    if (rstN && flashWrEn) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3 unexpected write", {flashWrAddr, flashWrData}, 32'h0);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check({flashWrAddr, flashWrData} == e[ADDR_W+7:0], "R3 write addr/data",
              {flashWrAddr, flashWrData}, e);
      end
    end
  end

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1;
    rxByte  = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  // drives a full page program; outcome predicted from the requirements
  task automatic runPage(input logic [7:0] mid, input logic [7:0] high, input bit junk, input string req);
    int page;
    bit blocked, done;
    int cnt;
    page    = {16'h0, high, mid};
    blocked = (page >= PAGE_CNT) || LOCK_MODEL[(page % PAGE_CNT) / PAGES_PER_BLOCK];
    done    = !blocked && progModel[page];
    if (!blocked && !done)
      for (int k = 0; k < 256; k++)
        expQ.push_back({8'h00, high, mid, 8'(k), pat(page, k)});
    sendByte(8'h41);
    sendByte(mid);
    sendByte(high);
    for (int k = 0; k < 256; k++) sendByte(pat(page, k));
    check(busy === 1'b1, "R4 busy after last byte", {31'h0, busy}, 32'h1);
    if (junk) begin
      sendByte(8'h50);
      sendByte(8'h41);
      sendByte(8'h07);
    end
    cnt = 0;
    while (busy && cnt < 2000) begin
      cnt++;
      @(negedge clk);
    end
    if (!junk)
      check(cnt == ((blocked || done) ? 1 : 257), req, cnt, (blocked || done) ? 1 : 257);
    if (blocked) expLockErr = 1;
    else if (done) expProgErr = 1;
    else progModel[page] = 1;
    check(expQ.size() == 0, {req, " write count"}, expQ.size(), 0);
    check(statusOut == expStatus(), {req, " status"}, statusOut, expStatus());
  endtask

  task automatic runClear();
    sendByte(8'h50);
    check(busy === 1'b1, "R2 busy raised", {31'h0, busy}, 32'h1);
    @(negedge clk);
    check(busy === 1'b0, "R2 busy one cycle", {31'h0, busy}, 32'h0);
    expLockErr = 0;
    expProgErr = 0;
    check(statusOut == 8'h80, "R2 errors cleared", statusOut, 8'h80);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < PAGE_CNT; p++) progModel[p] = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy === 1'b0, "R1 busy after reset", {31'h0, busy}, 32'h0);
    check(statusOut == 8'h80, "R1 status after reset", statusOut, 8'h80);

    // R6 unknown opcodes discarded
    sendByte(8'h33);
    check(busy === 1'b0, "R6 unknown opcode busy", {31'h0, busy}, 32'h0);
    sendByte(8'hA5);
    check(statusOut == 8'h80, "R6 unknown opcode status", statusOut, 8'h80);

    // R3/R4 good page right after junk opcodes
    runPage(8'h01, 8'h00, 0, "R3 R4 page 1");
    // R8 reprogram attempt
    runPage(8'h01, 8'h00, 0, "R8 reprogram page 1");
    // R5 bytes during busy are ignored (clear would drop the program error)
    runPage(8'h02, 8'h00, 1, "R5 page 2 with ignored bytes");
    // framing back at opcode: clear as the next first byte
    runClear();
    // R7 locked block
    runPage(8'h21, 8'h00, 0, "R7 locked page 33");
    runClear();
    // R9 beyond end of array (page 0x0101)
    runPage(8'h01, 8'h01, 0, "R9 out of range page");
    // R10 sticky until clear; clear keeps programmed record
    @(negedge clk);
    check(statusOut == 8'h88, "R10 lock error sticky", statusOut, 8'h88);
    runClear();
    runPage(8'h02, 8'h00, 0, "R10 rewrite after clear");
    runClear();
    // highest legal page in an unlocked block
    runPage(8'h3F, 8'h00, 0, "R3 last page");

    // flash model contents
    @(negedge clk);
    for (int k = 0; k < 256; k += 51) begin
      check(flashMem[256 + k] == pat(1, k), "R3 flash page 1", flashMem[256 + k], pat(1, k));
      check(flashMem[512 + k] == pat(2, k), "R3 flash page 2", flashMem[512 + k], pat(2, k));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule